// File: doc/BRIEF.md
# Horizontal Raster Position Counter

This block keeps the horizontal beam position for a small video display controller. An 8-bit counter advances on every cycle of the system clock, with no enable. When it reaches the terminal count of 70 it returns to zero on the next cycle, so a scan line is 71 clocks long. A second source, an external line-reset input, can force the counter back to zero at any time. The two sources are ORed together. While either one is active the counter does not advance.

The count feeds three consumers:
- A terminal-count decode flag, which looks at all eight bits.
- A light-pen capture register, which stores the low seven bits.
- A registered comparator that pulses when the low seven bits equal a programmable 7-bit horizontal origin.

The top bit is kept only for the decoder. The capture register and the comparator ignore it.

The light-pen strobe is asynchronous. It passes through a two-flop synchronizer, and its rising edge loads the capture register. After one capture, the register ignores further edges until a frame-clear pulse re-arms it.

Top module: `hraster_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the edge leaves `hpos`, `pen_x` and `origin_hit` at zero and re-arms the capture register.
- R2: When `hpos` is not 70 and `line_rst` is low, `hpos` increases by exactly one at the next clock edge.
- R3: When `hpos` is 70, it becomes 0 at the next clock edge, so with `line_rst` low `at_wrap` repeats every 71 cycles.
- R4: When `line_rst` is high at an edge, `hpos` becomes 0 at that edge. Holding `line_rst` high keeps `hpos` at 0.
- R5: `at_wrap` is high exactly while `hpos` equals 70, decoding all eight bits.
- R6: `hpos` never exceeds 70, so bit 7 of `hpos` stays 0.
- R7: `pen_strobe` is sampled by two synchronizer flops. If it first reads high at edge k, then at edge k+2 `pen_x` loads the value of `hpos[6:0]` that held between edges k+1 and k+2.
- R8: Once a capture has happened, later strobe rising edges leave `pen_x` unchanged until `frame_clr` is seen high at an edge. That edge re-arms capture and does not itself capture.
- R9: `origin_hit` goes high for exactly one cycle, one edge after the first cycle of a run of cycles in which `hpos[6:0]` equals `origin_x`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counter steps once per cycle |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| line_rst | input | 1 | External line reset, ORed with the terminal-count reset |
| pen_strobe | input | 1 | Asynchronous light-pen strobe |
| frame_clr | input | 1 | Re-arms the light-pen capture register |
| origin_x | input | 7 | Horizontal screen-origin value |
| hpos | output | 8 | Current horizontal position |
| at_wrap | output | 1 | Terminal-count decode, high when `hpos` is 70 |
| pen_x | output | 7 | Captured light-pen horizontal position |
| origin_hit | output | 1 | Registered single-cycle origin-match pulse |

## Verification
The bench aims at the cycle where the count turns over at 70. A design that wrapped on overflow, or one clock early or late, shows a line length other than 71 and an `at_wrap` in the wrong cycle.

It holds `line_rst` across several cycles and at the same time as the terminal count. A design that let the counter advance during reset would leave zero on the second cycle.

It sends strobe bursts within one frame to catch a capture register that accepts a second edge. It also checks the capture value against the exact synchronizer latency, because a missing or extra stage moves the captured position by one.

It holds the origin at zero while the line reset is held, which catches a comparator that outputs a level instead of a single pulse.

// File: rtl/hraster_pkg.sv
// Shared sizing for the horizontal raster counter.
// Assumes the line length stays well below 2**POS_W.
package hraster_pkg;
    localparam int CNT_W       = 8;   // counter width seen by the decoder
    localparam int POS_W       = 7;   // bits used by latch and comparator
    localparam int WRAP_COUNT  = 70;  // terminal count, last position on a line
    localparam int SYNC_STAGES = 2;   // light-pen synchronizer depth
endpackage

// File: rtl/hraster_count.sv
// Free-running horizontal position counter.
// Steps on every clock; returns to zero after the terminal count or on an
// external line reset. Assumes rst_n is synchronous to clk.
module hraster_count
    import hraster_pkg::*;
#(
    parameter int W    = CNT_W,
    parameter int LAST = WRAP_COUNT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         line_rst,
    output logic [W-1:0] cnt,
    output logic         at_last
);
    localparam logic [W-1:0] LAST_V = W'(LAST);

    logic clear_now;

    // Decode of the terminal count over all bits.
    always_comb at_last = (cnt == LAST_V);

    // Either reset source zeroes the counter and blocks the step.
    always_comb clear_now = at_last | line_rst;

    // Counter register: zero on reset or clear, otherwise increment.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_now) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != LAST_V && !line_rst) |=> (cnt == W'($past(cnt) + 1'b1))); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LAST_V) |=> (cnt == '0)); // R3
    AST_LINE_RST: assert property (@(posedge clk) disable iff (!rst_n)
        line_rst |=> (cnt == '0)); // R4
    AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= LAST_V)); // R6
endmodule

// File: rtl/hraster_pen.sv
// Light-pen horizontal capture register.
// Synchronizes an asynchronous strobe and loads the position on its rising
// edge, once per frame. frame_clr re-arms capture and wins over a
// same-cycle edge.
module hraster_pen
    import hraster_pkg::*;
#(
    parameter int PW     = POS_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic          frame_clr,
    input  logic [PW-1:0] pos,
    output logic [PW-1:0] pen_x
);
    logic [STAGES:0] sync_q;
    logic            armed;
    logic            rise;
    logic            take;

    // Synchronizer chain plus one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-1:0], strobe};
    end

    // Rising edge of the synchronized strobe.
    always_comb rise = sync_q[STAGES-1] & ~sync_q[STAGES];

    // Capture is allowed only while armed and not being cleared.
    always_comb take = rise & armed & ~frame_clr;

    // Arming state: cleared by a capture, set again by frame_clr.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_clr) armed <= 1'b1;
        else if (take)           armed <= 1'b0;
    end

    // Capture register.
    always_ff @(posedge clk) begin
        if (!rst_n)    pen_x <= '0;
        else if (take) pen_x <= pos;
    end

    AST_PEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !frame_clr) |=> $stable(pen_x)); // R8
    AST_PEN_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && armed && !frame_clr) |=> !armed); // R8
endmodule

// File: rtl/hraster_origin.sv
// Registered comparator of the low position bits against the origin.
// Emits one pulse per run of equal cycles. Assumes origin_x is quasi-static.
module hraster_origin
    import hraster_pkg::*;
#(
    parameter int PW = POS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pos,
    input  logic [PW-1:0] origin_x,
    output logic          hit
);
    logic eq_now;
    logic eq_prev;

    // Equality of the low bits; the top counter bit is not an input here.
    always_comb eq_now = (pos == origin_x);

    // Remember the previous compare and pulse on its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eq_prev <= 1'b0;
            hit     <= 1'b0;
        end else begin
            eq_prev <= eq_now;
            hit     <= eq_now & ~eq_prev;
        end
    end

    AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit); // R9
    AST_HIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> $past(eq_now)); // R9
endmodule

// File: rtl/hraster_counter.sv
// Top of the horizontal raster counter: the counter, the light-pen capture
// register and the origin comparator. Only the low POS_W bits leave toward
// the capture register and the comparator.
module hraster_counter
    import hraster_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_rst,
    input  logic             pen_strobe,
    input  logic             frame_clr,
    input  logic [POS_W-1:0] origin_x,
    output logic [CNT_W-1:0] hpos,
    output logic             at_wrap,
    output logic [POS_W-1:0] pen_x,
    output logic             origin_hit
);
    logic [POS_W-1:0] pos_low;

    // Low bits shared by the capture register and the comparator.
    always_comb pos_low = hpos[POS_W-1:0];

    hraster_count #(.W(CNT_W), .LAST(WRAP_COUNT)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_rst (line_rst),
        .cnt      (hpos),
        .at_last  (at_wrap)
    );

    hraster_pen #(.PW(POS_W), .STAGES(SYNC_STAGES)) u_pen (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (pen_strobe),
        .frame_clr (frame_clr),
        .pos       (pos_low),
        .pen_x     (pen_x)
    );

    hraster_origin #(.PW(POS_W)) u_origin (
        .clk      (clk),
        .rst_n    (rst_n),
        .pos      (pos_low),
        .origin_x (origin_x),
        .hit      (origin_hit)
    );

    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        at_wrap |=> (hpos == '0)); // R5
    AST_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        !hpos[CNT_W-1]); // R6
endmodule

// File: tb/hraster_counter_bench.sv
module hraster_counter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_rst = 1'b0;
    logic       pen_strobe = 1'b0;
    logic       frame_clr = 1'b0;
    logic [6:0] origin_x = 7'd0;
    logic [7:0] hpos;
    logic       at_wrap;
    logic [6:0] pen_x;
    logic       origin_hit;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Expected-state model built from the requirements.
    int m_h, m_pen, m_hit, m_eqp;
    bit m_armed;
    bit s1, s2, s3;

    always #2 clk = ~clk;

    hraster_counter u_hraster_counter (
        .clk(clk), .rst_n(rst_n), .line_rst(line_rst), .pen_strobe(pen_strobe),
        .frame_clr(frame_clr), .origin_x(origin_x), .hpos(hpos),
        .at_wrap(at_wrap), .pen_x(pen_x), .origin_hit(origin_hit)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int next_pos(int h, bit lr);
        return (h == 70 || lr) ? 0 : h + 1;
    endfunction

    task automatic model_edge();
        bit rise;
        bit eq;
        if (!rst_n) begin
            m_h = 0; m_pen = 0; m_hit = 0; m_eqp = 0; m_armed = 1;
            s1 = 0; s2 = 0; s3 = 0;
            return;
        end
        rise = s2 && !s3;
        eq = ((m_h % 128) == int'(origin_x));
        if (rise && m_armed && !frame_clr) begin
            m_pen = m_h % 128;
            m_armed = 0;
        end
        if (frame_clr) m_armed = 1;
        m_hit = (eq && !m_eqp) ? 1 : 0;
        m_eqp = eq ? 1 : 0;
        s3 = s2; s2 = s1; s1 = pen_strobe;
        m_h = next_pos(m_h, line_rst);
    endtask

    task automatic compare_all();
        check("R2/R3/R4", "hpos", int'(hpos), m_h);
        check("R5", "at_wrap", int'(at_wrap), (m_h == 70) ? 1 : 0);
        check("R6", "hpos bit7", int'(hpos[7]), 0);
        check("R7", "pen_x", int'(pen_x), m_pen);
        check("R9", "origin_hit", int'(origin_hit), m_hit);
    endtask

    task automatic step(input bit r, input bit lr, input bit st, input bit fc, input int org);
        @(negedge clk);
        rst_n = r; line_rst = lr; pen_strobe = st; frame_clr = fc; origin_x = 7'(org);
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int wrap_at;
        int span;
        int held;
        void'($urandom(32'd1234));
        // R1: reset state
        step(0, 0, 0, 0, 5);
        step(0, 1, 1, 1, 5);
        check("R1", "hpos reset", int'(hpos), 0);
        check("R1", "pen_x reset", int'(pen_x), 0);
        check("R1", "origin_hit reset", int'(origin_hit), 0);
        step(0, 0, 0, 0, 5);
        // R3: line period of 71 clocks
        wrap_at = -1;
        span = 0;
        for (int i = 0; i < 160; i++) begin
            step(1, 0, 0, 0, 5);
            if (at_wrap) begin
                if (wrap_at >= 0) span = i - wrap_at;
                wrap_at = i;
            end
        end
        check("R3", "line period", span, 71);
        // R4: held line reset keeps position at zero, also during terminal count
        while (hpos != 8'd69) step(1, 0, 0, 0, 5);
        step(1, 0, 0, 0, 5);
        step(1, 1, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 0);
        check("R4", "held reset", int'(hpos), 0);
        // R9: origin 0 with reset held gave a single pulse only
        step(1, 0, 0, 0, 0);
        // R7/R8: capture once, ignore second burst, re-arm on frame_clr
        step(1, 0, 0, 1, 5);
        for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 5);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 5);
        held = int'(pen_x);
        for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 5);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 5);
        check("R8", "ignored second edge", int'(pen_x), held);
        step(1, 0, 0, 1, 5);
        for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 5);
        check("R8", "rearmed capture", int'(pen_x), m_pen);
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            bit lr, st, fc;
            int org;
            lr = ($urandom_range(0, 99) < 3);
            st = ($urandom_range(0, 99) < 15) ? ~pen_strobe : pen_strobe;
            fc = ($urandom_range(0, 99) < 4);
            org = ($urandom_range(0, 99) < 5) ? $urandom_range(0, 127) : int'(origin_x);
            step(($urandom_range(0, 999) != 0), lr, st, fc, org);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule